// File: doc/BRIEF.md
# Two-Mode Interval Counter Channel

This block is one down-counter channel for a programmable interval timer. It is built for a system clock domain and steps on a separate, slower count clock. A bus-side write selects one of two behaviours and sets the initial count. In rate mode the channel divides its count clock by the loaded value. In strobe mode a rising edge on the gate input starts a single countdown. In both modes the active-low output drops for exactly one count-clock period when the terminal count is reached.

Channels are meant to be chained. One channel in rate mode acts as a prescaler, and its output serves as the count clock of further channels. For example, dividing a 1 MHz clock by 8 gives 125 kHz. A further divide by 62500 gives a 2 Hz tick. A strobe count of 150 at 125 kHz places the pulse 1.2 ms after the gate edge. Rising edges of the count clock and the gate are found through synchronisers and edge detection in the system clock domain, so nothing inside the block is clocked by them.

Top module: `ic_channel`

## Requirements
- R1: After reset the output is high, and it stays high on every count-clock edge until the first configuration write.
- R2: A write with wr_en_i high captures wr_mode_i (0 selects rate mode, 1 selects strobe mode) and wr_count_i. The output is high two system cycles later, and the countdown restarts from the new count, even in the middle of a period or during a low pulse.
- R3: In rate mode with a count N of 2 or more, the output is low during the count-clock period that follows the N-th rising count-clock edge after the write. It then repeats every N edges. Loading 8 divides the count clock by 8.
- R4: In both modes each low pulse lasts exactly one count-clock period. The output returns high on the next rising count-clock edge.
- R5: In rate mode the gate input has no effect on the output sequence.
- R6: In strobe mode, after a write and before any gate rising edge, the output stays high whatever the count clock does.
- R7: In strobe mode a gate rising edge loads the count N. The output is low for one period after the N-th following count-clock edge, then stays high until the next gate rising edge.
- R8: In strobe mode, a gate rising edge during a running countdown restarts the count from N.
- R9: Each rising edge of the count clock advances the count exactly once, however long the count clock stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cnt_clk_i | input | 1 | Count clock, sampled and edge-detected |
| gate_i | input | 1 | Trigger input for strobe mode, sampled and edge-detected |
| wr_en_i | input | 1 | Configuration write strobe, one system cycle |
| wr_mode_i | input | 1 | Mode on write: 0 rate, 1 strobe |
| wr_count_i | input | WIDTH | Initial count on write |
| out_n_o | output | 1 | Registered active-low counter output |

## Verification
On every cycle, the assertions check these properties:
- The output moves only on a count-clock tick or a load.
- The output is high after a load.
- A low pulse ends at the next tick.
- A falling edge happens only while counting and at a count of one.
- A detected count-clock edge lasts one cycle.
- An idle strobe channel stays idle without a trigger.

Only the bench scenarios can show the complete tick patterns: the divide ratios, the strobe delay measured in count-clock edges, restart on a second gate edge, gate independence in rate mode, and single counting with a long-high count clock.

// File: rtl/ic_pkg.sv
package ic_pkg;
  typedef enum logic {
    IC_RATE   = 1'b0,
    IC_STROBE = 1'b1
  } ic_mode_e;
endpackage

// File: rtl/ic_edge_sync.sv
module ic_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ic_cfg_reg.sv
module ic_cfg_reg
  import ic_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_en_i,
  input  logic             wr_mode_i,
  input  logic [WIDTH-1:0] wr_count_i,
  output ic_mode_e         mode_o,
  output logic [WIDTH-1:0] init_o,
  output logic             load_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_o <= IC_RATE;
      init_o <= '0;
      load_o <= 1'b0;
    end else begin
      load_o <= wr_en_i;
      if (wr_en_i) begin
        mode_o <= ic_mode_e'(wr_mode_i);
        init_o <= wr_count_i;
      end
    end
  end
endmodule

// File: rtl/ic_downcount.sv
module ic_downcount
  import ic_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  ic_mode_e         mode_i,
  input  logic [WIDTH-1:0] init_i,
  input  logic             tick_i,
  input  logic             trig_i,
  output logic             out_n_o,
  output logic             running_o,
  output logic [WIDTH-1:0] cnt_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic terminal;
  assign terminal = running_o && (cnt_o == ONE);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_o     <= '0;
      running_o <= 1'b0;
      out_n_o   <= 1'b1;
    end else if (load_i) begin
      cnt_o     <= init_i;
      running_o <= (mode_i == IC_RATE);
      out_n_o   <= 1'b1;
    end else if (trig_i) begin
      cnt_o     <= init_i;
      running_o <= 1'b1;
      if (tick_i) out_n_o <= 1'b1;
    end else if (tick_i) begin
      if (terminal) begin
        out_n_o <= 1'b0;
        if (mode_i == IC_RATE) cnt_o <= init_i;
        else                   running_o <= 1'b0;
      end else begin
        out_n_o <= 1'b1;
        if (running_o) cnt_o <= cnt_o - ONE;
      end
    end
  end
endmodule

// File: rtl/ic_channel.sv
module ic_channel
  import ic_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             cnt_clk_i,
  input  logic             gate_i,
  input  logic             wr_en_i,
  input  logic             wr_mode_i,
  input  logic [WIDTH-1:0] wr_count_i,
  output logic             out_n_o
);
  logic             cnt_tick;
  logic             gate_rise;
  logic             strobe_trig;
  logic             load_pulse;
  ic_mode_e         cfg_mode;
  logic [WIDTH-1:0] cfg_init;
  logic             run_flag;
  logic [WIDTH-1:0] cnt_val;

  ic_edge_sync #(.STAGES(SYNC_STAGES)) u_clk_edge (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (cnt_clk_i),
    .rise_o(cnt_tick)
  );

  ic_edge_sync #(.STAGES(SYNC_STAGES)) u_gate_edge (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (gate_i),
    .rise_o(gate_rise)
  );

  ic_cfg_reg #(.WIDTH(WIDTH)) u_cfg (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_en_i   (wr_en_i),
    .wr_mode_i (wr_mode_i),
    .wr_count_i(wr_count_i),
    .mode_o    (cfg_mode),
    .init_o    (cfg_init),
    .load_o    (load_pulse)
  );

  assign strobe_trig = gate_rise && (cfg_mode == IC_STROBE);

  ic_downcount #(.WIDTH(WIDTH)) u_core (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .load_i   (load_pulse),
    .mode_i   (cfg_mode),
    .init_i   (cfg_init),
    .tick_i   (cnt_tick),
    .trig_i   (strobe_trig),
    .out_n_o  (out_n_o),
    .running_o(run_flag),
    .cnt_o    (cnt_val)
  );
endmodule

// File: rtl/ic_channel_chk.sv
module ic_channel_chk
  import ic_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             cnt_tick,
  input logic             load_pulse,
  input logic             strobe_trig,
  input logic             run_flag,
  input logic [WIDTH-1:0] cnt_val,
  input ic_mode_e         cfg_mode,
  input logic             out_n_o
);
  // R1
  quiet_between_ticks_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!cnt_tick && !load_pulse) |=> $stable(out_n_o));

  // R2
  load_idle_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    load_pulse |=> out_n_o);

  // R4
  pulse_one_period_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!out_n_o && cnt_tick && !load_pulse && !(run_flag && cnt_val == WIDTH'(1))) |=> out_n_o);

  // R3
  fall_at_terminal_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(out_n_o) |-> ($past(run_flag) && $past(cnt_val) == WIDTH'(1)));

  // R9
  tick_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_tick |=> !cnt_tick);

  // R6
  strobe_stays_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cfg_mode == IC_STROBE && !run_flag && !strobe_trig && !load_pulse) |=> !run_flag);
endmodule

bind ic_channel ic_channel_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .cnt_tick   (cnt_tick),
  .load_pulse (load_pulse),
  .strobe_trig(strobe_trig),
  .run_flag   (run_flag),
  .cnt_val    (cnt_val),
  .cfg_mode   (cfg_mode),
  .out_n_o    (out_n_o)
);

// File: tb/ic_channel_bench.sv
module ic_channel_bench;
  localparam int WIDTH = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cnt_clk = 1'b0;
  logic             gate = 1'b0;
  logic             wr_en = 1'b0;
  logic             wr_mode = 1'b0;
  logic [WIDTH-1:0] wr_count = '0;
  logic             out_n;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ic_channel #(.WIDTH(WIDTH)) u_ic_channel (
    .clk_i     (clk),
    .rst_i     (rst),
    .cnt_clk_i (cnt_clk),
    .gate_i    (gate),
    .wr_en_i   (wr_en),
    .wr_mode_i (wr_mode),
    .wr_count_i(wr_count),
    .out_n_o   (out_n)
  );

  // {mode, count, expected tick of first low pulse}
  localparam logic [32:0] VECS [0:5] = '{
    {1'b0, 16'd8,   16'd8},
    {1'b0, 16'd3,   16'd3},
    {1'b0, 16'd2,   16'd2},
    {1'b1, 16'd150, 16'd150},
    {1'b1, 16'd5,   16'd5},
    {1'b1, 16'd1,   16'd1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one count-clock period; returns the output sampled in the low phase
  task automatic tick(input int hi, output logic o);
    cnt_clk = 1'b1;
    repeat (hi) @(posedge clk);
    #1 cnt_clk = 1'b0;
    repeat (4) @(posedge clk);
    #1 o = out_n;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic write_cfg(input logic m, input logic [WIDTH-1:0] n);
    wr_en = 1'b1; wr_mode = m; wr_count = n;
    @(posedge clk);
    #1 wr_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic pulse_gate();
    gate = 1'b1;
    repeat (3) @(posedge clk);
    #1 gate = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic o;
    int bad_k, bad_v, bad_e;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    // R1 reset state
    check(out_n === 1'b1, "R1 reset out", out_n, 1);
    bad_k = 0;
    for (int k = 1; k <= 5; k++) begin
      tick(8, o);
      if (o !== 1'b1 && bad_k == 0) bad_k = k;
    end
    check(bad_k == 0, "R1 high before config (tick)", bad_k, 0);

    // vector table: R3 R4 R7
    for (int i = 0; i < 6; i++) begin
      logic m;
      int n, first;
      m = VECS[i][32];
      n = int'(VECS[i][31:16]);
      first = int'(VECS[i][15:0]);
      write_cfg(m, 16'(n));
      if (m) pulse_gate();
      bad_k = 0; bad_v = 0; bad_e = 0;
      for (int k = 1; k <= 2*first + 2; k++) begin
        logic e;
        tick(8, o);
        e = m ? (k != first) : ((k % first) != 0);
        if (o !== e && bad_k == 0) begin bad_k = k; bad_v = int'(o); bad_e = int'(e); end
      end
      check(bad_k == 0, m ? "R7 R4 strobe pattern" : "R3 R4 rate pattern", bad_v, bad_e);
    end

    // R6 strobe idle without gate
    write_cfg(1'b1, 16'd3);
    bad_k = 0;
    for (int k = 1; k <= 10; k++) begin
      tick(8, o);
      if (o !== 1'b1 && bad_k == 0) bad_k = k;
    end
    check(bad_k == 0, "R6 strobe idle (tick)", bad_k, 0);

    // R5 gate ignored in rate mode
    write_cfg(1'b0, 16'd4);
    bad_k = 0;
    for (int k = 1; k <= 12; k++) begin
      pulse_gate();
      tick(8, o);
      if (o !== ((k % 4) != 0) && bad_k == 0) bad_k = k;
    end
    check(bad_k == 0, "R5 gate ignored (tick)", bad_k, 0);

    // R8 retrigger
    write_cfg(1'b1, 16'd6);
    pulse_gate();
    bad_k = 0;
    for (int k = 1; k <= 3; k++) begin
      tick(8, o);
      if (o !== 1'b1 && bad_k == 0) bad_k = k;
    end
    pulse_gate();
    for (int k = 4; k <= 14; k++) begin
      tick(8, o);
      if (o !== (k != 9) && bad_k == 0) bad_k = k;
    end
    check(bad_k == 0, "R8 retrigger low at tick 9 (tick)", bad_k, 0);

    // R9 long-high count clock
    write_cfg(1'b0, 16'd3);
    bad_k = 0;
    for (int k = 1; k <= 9; k++) begin
      tick(40, o);
      if (o !== ((k % 3) != 0) && bad_k == 0) bad_k = k;
    end
    check(bad_k == 0, "R9 one count per edge (tick)", bad_k, 0);

    // R2 rewrite mid-period restarts
    write_cfg(1'b0, 16'd5);
    for (int k = 1; k <= 4; k++) tick(8, o);
    write_cfg(1'b0, 16'd2);
    check(out_n === 1'b1, "R2 high after rewrite", out_n, 1);
    tick(8, o);
    check(o === 1'b1, "R2 new count tick 1", o, 1);
    tick(8, o);
    check(o === 1'b0, "R2 new count tick 2", o, 0);
    // R2 rewrite during low pulse
    write_cfg(1'b1, 16'd2);
    check(out_n === 1'b1, "R2 high after write in pulse", out_n, 1);
    tick(8, o);
    check(o === 1'b1, "R2 strobe idle after rewrite", o, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule